// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is the target side of a two-wire serial memory bus, limited to read traffic. It watches the clock and data lines, finds start and stop conditions, matches a 7-bit device select code and shifts bytes in and out bit by bit. The data line is open-drain: the block never drives it high, it only asserts an enable that pulls the line low. The stored bytes come from a fixed function of the address, so no write path is needed.

A persistent address counter sits at the centre of the block. A write-direction frame that carries only two address bytes loads the counter. The counter then keeps its value across stop conditions. Reads return the byte at the counter and step it forward. A controller can issue a current-address read (select with the read bit set). It can issue a random read (address frame, repeated start, read select). Either read becomes sequential when the controller acknowledges a byte. The controller ends a read by leaving the last byte unacknowledged and sending a stop.

Top module: `i2cRdTarget`

## Requirements
- R1: After reset the data line is released (sdaOe low) and the address counter holds 0, so the first current-address read returns the byte at address 0.
- R2: A start condition (data falls while the clock is high) restarts byte framing at the device select, even in the middle of a byte. A stop condition (data rises while the clock is high) returns the block to idle.
- R3: The block responds only when bits 7:1 of the first byte after a start equal DEV_ADDR. Bit 0 is the direction bit, 1 meaning read. On a mismatch it gives no acknowledge, does not drive the line for the rest of the frame, and leaves the counter unchanged.
- R4: With direction bit 0, the next two bytes are the word address, high byte first. After the second byte the counter takes the low ADDR_W bits of the 16-bit value, and the upper bits are dropped.
- R5: Further bytes in the same write frame are not acknowledged and do not change the counter. A frame that ends after only one address byte leaves the counter unchanged.
- R6: A repeated start after the address bytes, with no stop in between, followed by a read select returns the byte at the address just loaded.
- R7: A current-address read (start, then select with direction bit 1) returns the byte at the counter. The counter value survives stop conditions between frames.
- R8: The counter steps by one after every byte sent. When the controller acknowledges a byte (data low on the ninth clock), the block sends the byte at the next address.
- R9: When the controller does not acknowledge a byte, the block releases the data line and drives nothing more until the next start.
- R10: The counter wraps from 2^ADDR_W-1 to 0.
- R11: The byte at address A is ((7*A + DATA_SEED) mod 256) XOR (A >> 8), sent most significant bit first. The block changes the line only while the clock is low.
- R12: The block acknowledges a matching select and each address byte by pulling the data line low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull-down enable for the data line (1 = drive low) |

## Verification
The bench builds the block with ADDR_W = 10, DEV_ADDR = 7'h53 and DATA_SEED = 8'h3C. The narrow counter lets a random read near address 1023 cross the wrap within two bytes. It also makes a 16-bit address with high bits set show the truncation of R4. The odd select code makes a neighbouring code (7'h52) a one-bit mismatch. The slow bus clock (20 system clocks per bit) leaves room to sample each bit early and late in the high phase, which checks that the data line is stable while the clock is high.

// File: rtl/i2cRdPkg.sv
package i2cRdPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACKD,
    ST_AHI,
    ST_ACKH,
    ST_ALO,
    ST_ACKL,
    ST_HOLD,
    ST_TX,
    ST_MACK
  } ctrlSt_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic countBit;
    logic latchHi;
    logic loadAddr;
    logic loadTx;
    logic shiftOut;
    logic incAddr;
  } dpStrobe_t;

endpackage

// File: rtl/i2cRdLineCond.sv
module i2cRdLineCond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclSh;
  logic [SYNC_STAGES-1:0] sdaSh;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
          sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl   = sclSh[SYNC_STAGES-1];
  assign sdaLvl   = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cRdData.sv
module i2cRdData
  import i2cRdPkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter logic [7:0] DATA_SEED = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaLvl,
  output logic [7:0]        rxByte,
  output logic              bitsFull,
  output logic              txNext,
  output logic              loadMsb,
  output logic [3:0]        bitCnt,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic [7:0] rxSh;
  logic [7:0] hiByte;
  logic [6:0] txSh;
  logic [7:0] curByte;

  function automatic logic [7:0] romByte(input logic [ADDR_W-1:0] a);
    logic [15:0] ax;
    logic [7:0]  mix;
    ax  = 16'(a);
    mix = 8'(ax * 16'd7) + DATA_SEED;
    return mix ^ ax[15:8];
  endfunction

  assign curByte = romByte(addrCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxSh    <= '0;
      hiByte  <= '0;
      txSh    <= '0;
      addrCnt <= '0;
    end else begin
      if (strb.clrBits)  bitCnt <= '0;
      if (strb.shiftIn) begin
        rxSh   <= {rxSh[6:0], sdaLvl};
        bitCnt <= bitCnt + 4'd1;
      end
      if (strb.countBit) bitCnt <= bitCnt + 4'd1;
      if (strb.latchHi)  hiByte <= rxSh;
      if (strb.loadAddr) addrCnt <= ADDR_W'({hiByte, rxSh});
      if (strb.loadTx) begin
        txSh   <= curByte[6:0];
        bitCnt <= '0;
      end
      if (strb.shiftOut) txSh <= {txSh[5:0], 1'b0};
      if (strb.incAddr)  addrCnt <= addrCnt + 1'b1;
    end
  end

  assign rxByte   = rxSh;
  assign bitsFull = (bitCnt == BYTE_BITS);
  assign txNext   = txSh[6];
  assign loadMsb  = curByte[7];

endmodule

// File: rtl/i2cRdCtrl.sv
module i2cRdCtrl
  import i2cRdPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic       bitsFull,
  input  logic       txNext,
  input  logic       loadMsb,
  output dpStrobe_t  strb,
  output logic       sdaOe,
  output ctrlSt_t    ctrlState
);

  ctrlSt_t st, stNext;
  logic    oeNext;
  logic    ackSeen, ackNext;

  always_comb begin
    stNext  = st;
    oeNext  = sdaOe;
    ackNext = ackSeen;
    strb    = '0;
    if (stopDet) begin
      stNext = ST_IDLE;
      oeNext = 1'b0;
    end else if (startDet) begin
      stNext       = ST_DEV;
      oeNext       = 1'b0;
      strb.clrBits = 1'b1;
    end else begin
      unique case (st)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (sclRise && !bitsFull) begin
            strb.shiftIn = 1'b1;
          end else if (sclFall && bitsFull) begin
            if (st == ST_DEV) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stNext = ST_ACKD;
                oeNext = 1'b1;
              end else begin
                stNext = ST_IDLE;
              end
            end else if (st == ST_AHI) begin
              stNext       = ST_ACKH;
              oeNext       = 1'b1;
              strb.latchHi = 1'b1;
            end else begin
              stNext        = ST_ACKL;
              oeNext        = 1'b1;
              strb.loadAddr = 1'b1;
            end
          end
        end
        ST_ACKD: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              stNext      = ST_TX;
              strb.loadTx = 1'b1;
              oeNext      = ~loadMsb;
            end else begin
              stNext       = ST_AHI;
              strb.clrBits = 1'b1;
              oeNext       = 1'b0;
            end
          end
        end
        ST_ACKH: begin
          if (sclFall) begin
            stNext       = ST_ALO;
            strb.clrBits = 1'b1;
            oeNext       = 1'b0;
          end
        end
        ST_ACKL: begin
          if (sclFall) begin
            stNext = ST_HOLD;
            oeNext = 1'b0;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            strb.countBit = 1'b1;
          end else if (sclFall) begin
            if (bitsFull) begin
              stNext       = ST_MACK;
              oeNext       = 1'b0;
              strb.incAddr = 1'b1;
              ackNext      = 1'b0;
            end else begin
              strb.shiftOut = 1'b1;
              oeNext        = ~txNext;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            ackNext = ~sdaLvl;
          end else if (sclFall) begin
            if (ackSeen) begin
              stNext      = ST_TX;
              strb.loadTx = 1'b1;
              oeNext      = ~loadMsb;
            end else begin
              stNext = ST_IDLE;
              oeNext = 1'b0;
            end
          end
        end
        default: begin
          oeNext = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      sdaOe   <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      st      <= stNext;
      sdaOe   <= oeNext;
      ackSeen <= ackNext;
    end
  end

  assign ctrlState = st;

endmodule

// File: rtl/i2cRdTarget.sv
module i2cRdTarget
  import i2cRdPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 12,
  parameter logic [7:0] DATA_SEED   = 8'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  logic              sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  dpStrobe_t         strb;
  logic [7:0]        rxByte;
  logic              bitsFull, txNext, loadMsb;
  logic [3:0]        bitCnt;
  logic [ADDR_W-1:0] addrCnt;
  ctrlSt_t           ctrlState;

  i2cRdLineCond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cRdCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .bitsFull(bitsFull), .txNext(txNext), .loadMsb(loadMsb),
    .strb(strb), .sdaOe(sdaOe), .ctrlState(ctrlState)
  );

  i2cRdData #(.ADDR_W(ADDR_W), .DATA_SEED(DATA_SEED)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .bitsFull(bitsFull), .txNext(txNext), .loadMsb(loadMsb),
    .bitCnt(bitCnt), .addrCnt(addrCnt)
  );

endmodule

// File: rtl/i2cRdTargetChk.sv
module i2cRdTargetChk
  import i2cRdPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              startDet,
  input logic              stopDet,
  input logic              sdaOe,
  input ctrlSt_t           ctrlState,
  input logic [3:0]        bitCnt,
  input logic              incAddr,
  input logic [ADDR_W-1:0] addrCnt
);

  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclLvl)); // R11

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaOe); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !sdaOe); // R3

  AST_START_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    $past(startDet) |-> (bitCnt == 4'd0 && ctrlState == ST_DEV)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(incAddr) |-> (addrCnt == ADDR_W'($past(addrCnt) + 1'b1))); // R8

endmodule

bind i2cRdTarget i2cRdTargetChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .ctrlState(ctrlState),
  .bitCnt(bitCnt), .incAddr(strb.incAddr), .addrCnt(addrCnt)
);

// File: tb/i2cRdTarget_tb.sv
`timescale 1ns/1ps
module i2cRdTarget_tb;

  localparam logic [6:0] DEV  = 7'h53;
  localparam int         AW   = 10;
  localparam int         SEED = 60;
  localparam logic [7:0] SEL_WR = {DEV, 1'b0};
  localparam logic [7:0] SEL_RD = {DEV, 1'b1};

  // vector: {word address, byte count}
  localparam logic [23:0] VEC [0:5] = '{
    {16'h0010, 8'd1},
    {16'h0123, 8'd3},
    {16'h03FE, 8'd4},
    {16'hFC05, 8'd2},
    {16'h0200, 8'd1},
    {16'h00FF, 8'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic mLow = 1'b0;
  logic sdaOe;
  logic sdaBus;
  int   nChk = 0;
  int   nFail = 0;

  assign sdaBus = ~(sdaOe | mLow);

  always #10 clk = ~clk;

  i2cRdTarget #(.DEV_ADDR(DEV), .ADDR_W(AW), .DATA_SEED(8'(SEED))) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe)
  );

  function automatic int expB(int a);
    int m;
    m = a & ((1 << AW) - 1);
    return ((7 * m + SEED) & 255) ^ ((m >> 8) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic drv, output logic early, output logic late);
    mLow = ~drv;
    tick(5);
    sclM = 1'b1;
    tick(3);
    early = sdaBus;
    tick(5);
    late = sdaBus;
    tick(2);
    sclM = 1'b0;
    tick(5);
  endtask

  task automatic busStart();
    mLow = 1'b0;
    tick(5);
    sclM = 1'b1;
    tick(5);
    mLow = 1'b1;
    tick(5);
    sclM = 1'b0;
    tick(5);
  endtask

  task automatic busStop();
    mLow = 1'b1;
    tick(5);
    sclM = 1'b1;
    tick(5);
    mLow = 1'b0;
    tick(5);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic e, l;
    for (int i = 7; i >= 0; i--) clockBit(b[i], e, l);
    clockBit(1'b1, e, l);
    ack = ~e;
  endtask

  task automatic readByte(output logic [7:0] b, input logic ackIt);
    logic e, l;
    int   unstable;
    unstable = 0;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, e, l);
      b[i] = e;
      if (e !== l) unstable++;
    end
    check("R11 data stable while clock high", unstable, 0);
    clockBit(~ackIt, e, l);
  endtask

  task automatic readRun(input int first, input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      readByte(b, k < n - 1);
      check(req, int'(b), expB(first + k));
    end
  endtask

  task automatic currentRead(input int first, input int n, input string req);
    logic ack;
    busStart();
    writeByte(SEL_RD, ack);
    check("R12 read select acknowledged", int'(ack), 1);
    readRun(first, n, req);
    busStop();
  endtask

  task automatic loadAddr(input logic [15:0] a);
    logic ack;
    busStart();
    writeByte(SEL_WR, ack);
    check("R12 write select acknowledged", int'(ack), 1);
    writeByte(a[15:8], ack);
    check("R4 high address byte acknowledged", int'(ack), 1);
    writeByte(a[7:0], ack);
    check("R4 low address byte acknowledged", int'(ack), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic ack, e, l;
    int   hiSeen;
    tick(4);
    check("R1 data line released in reset", int'(sdaBus), 1);
    rstN = 1'b1;
    tick(4);
    check("R1 data line released after reset", int'(sdaOe), 0);

    // R1 / R7: counter starts at zero
    currentRead(0, 2, "R1 first current read from address 0");

    // table of random and sequential random reads (R6, R8, R10, R4)
    for (int v = 0; v < 6; v++) begin
      loadAddr(VEC[v][23:8]);
      busStart();
      writeByte(SEL_RD, ack);
      check("R6 read select after repeated start acknowledged", int'(ack), 1);
      readRun(int'(VEC[v][23:8]), int'(VEC[v][7:0]), "R6 R8 R10 random read data");
      busStop();
    end

    // R7: counter persists across STOP (last vector ended at 0x101)
    currentRead(16'h0101, 1, "R7 current read continues after stop");

    // R4: address frame closed by STOP, then current read
    loadAddr(16'h02AA);
    busStop();
    currentRead(16'h02AA, 1, "R4 counter loaded by address-only frame");

    // R5: extra byte in write frame gets no acknowledge, counter kept
    loadAddr(16'h0155);
    writeByte(8'h99, ack);
    check("R5 extra write byte not acknowledged", int'(ack), 0);
    busStop();
    currentRead(16'h0155, 1, "R5 counter unchanged by extra byte");

    // R5: partial frame with one address byte leaves counter alone
    busStart();
    writeByte(SEL_WR, ack);
    writeByte(8'h01, ack);
    busStop();
    currentRead(16'h0156, 1, "R5 partial frame leaves counter");

    // R3: mismatched select
    busStart();
    writeByte({7'h52, 1'b1}, ack);
    check("R3 mismatched select not acknowledged", int'(ack), 0);
    hiSeen = 0;
    for (int i = 0; i < 9; i++) begin
      clockBit(1'b1, e, l);
      hiSeen += int'(e & l);
    end
    check("R3 no drive after mismatch", hiSeen, 9);
    busStop();
    currentRead(16'h0157, 1, "R3 counter unchanged after mismatch");

    // R9: after NACK the line stays released
    busStart();
    writeByte(SEL_RD, ack);
    readRun(16'h0158, 1, "R9 byte before release");
    hiSeen = 0;
    for (int i = 0; i < 9; i++) begin
      clockBit(1'b1, e, l);
      hiSeen += int'(e & l);
    end
    check("R9 line released after NACK", hiSeen, 9);
    busStop();

    // R2: START in the middle of a byte restarts framing
    busStart();
    clockBit(1'b1, e, l);
    clockBit(1'b0, e, l);
    clockBit(1'b1, e, l);
    busStart();
    writeByte(SEL_RD, ack);
    check("R2 select after mid-byte start acknowledged", int'(ack), 1);
    readRun(16'h0159, 1, "R2 read after restart");
    busStop();

    // R8: sequential current read
    currentRead(16'h015A, 3, "R8 sequential current read");

    // R10: wrap exactly at the top address via current read
    loadAddr(16'h03FF);
    busStop();
    currentRead(16'h03FF, 2, "R10 wrap to zero");
    currentRead(16'h0001, 1, "R10 counter after wrap");

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule